// File: doc/BRIEF.md
# Up-Counting Reload-Match PWM Timer

The block is a free-running up-counter that produces a pulse-width modulated output. The counter starts at a reload value and counts up towards all-ones. On the overflow step it reloads and the waveform goes to its active level. When the counter equals a compare value the waveform drops to its idle level. The period therefore follows from the distance between the reload value and the overflow point, and the duty follows from where the compare value sits inside that range. A period of P cycles uses reload = all-ones - P + 1. A duty of D cycles uses compare = reload + D - 1.

Software drives the block through a single write-strobe port with three registers: a control word, the reload value and the compare value. Writes take effect at once. New reload or compare values written while the timer runs are picked up at the next reload or the next compare, so one period may mix old and new settings. Clearing the run bit halts the counter on the next edge. An invert setting swaps the output levels. It is accepted only while the timer is stopped. Two status outputs show whether the timer runs and whether the output is inverted.

Top module: `upmatch_pwm`

## Requirements
- R1: After reset, pwm_out is 0, running is 0 and inverted is 0.
- R2: A write with wr_addr 0 is a control write: wr_data bit 0 is the run bit and wr_data bit 1 is the invert bit. wr_addr 1 writes the reload register and wr_addr 2 writes the compare register. Each write takes effect at the clock edge where wr_en is sampled high.
- R3: A control write with the run bit set while the timer is stopped sets running. On that same edge it loads the counter with the reload value, and the output is at its active level in the first running cycle. A control write with the run bit set while the timer is already running does not restart the counter.
- R4: While running, the counter goes up by one each clock. From all-ones it reloads from the reload register and the output goes active, which gives a period of P cycles for reload = 0xFFFFFFFF - P + 1.
- R5: While running, when the counter equals the compare register, the output goes idle from the next cycle. This gives D active cycles for compare = reload + D - 1. If the counter is all-ones and also equals the compare value, the reload wins and the output stays active.
- R6: A control write with the run bit clear halts the counter on that edge, without finishing the period. The counter then holds its value until the next start.
- R7: The invert bit is stored only when the timer was stopped before the control write; otherwise it is ignored. The inverted output equals the active-high waveform flipped, and the inverted output port shows the stored bit.
- R8: A reload write of 0xFFFFFFFF is stored as 0xFFFFFFFE, so the shortest period is 2 cycles.
- R9: Reload and compare writes made while running do not disturb the counter. A new compare value is used at the next compare, and a new reload value at the next overflow, so one period may combine old and new settings.
- R10: While stopped, pwm_out equals the inverted bit, which is the idle level for the current polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 reload, 2 compare |
| wr_data | input | 32 | Write data |
| pwm_out | output | 1 | PWM waveform |
| running | output | 1 | Timer is counting |
| inverted | output | 1 | Output polarity is inverted |

## Verification
Random periods and duties are set up while the timer is stopped and started with a random polarity. Each output cycle is compared with the ideal waveform computed from the period and duty alone, which separates off-by-one errors in the reload and in the compare. Directed sequences cover several corner cases: the 2-cycle minimum reached through the reload clamp, and a compare placed on the overflow count, which shows whether the reload takes priority. A stop in mid-pulse followed by a restart shows whether the counter is reinitialised rather than resumed. Writes while running cover three cases: reload and compare changed partway through a period, which must produce one mixed period and then the new waveform; a polarity change attempted while running; and a repeated run write, which must cause no phase jump.

// File: rtl/upmatch_pwm_pkg.sv
package upmatch_pwm_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL  = 2'd0,
    ADDR_LOAD  = 2'd1,
    ADDR_MATCH = 2'd2,
    ADDR_SPARE = 2'd3
  } reg_addr_e;

  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_INV_BIT = 1;
endpackage

// File: rtl/upmatch_pwm_regs.sv
module upmatch_pwm_regs
  import upmatch_pwm_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] load_q,
  output logic [W-1:0] match_q,
  output logic         run_q,
  output logic         inv_q,
  output logic         start_evt
);
  localparam logic [W-1:0] LOAD_MAX = {{(W-1){1'b1}}, 1'b0};

  function automatic logic [W-1:0] clamp_load(input logic [W-1:0] v);
    return (v == {W{1'b1}}) ? LOAD_MAX : v;
  endfunction

  logic ctrl_wr;
  assign ctrl_wr   = wr_en && (reg_addr_e'(wr_addr) == ADDR_CTRL);
  assign start_evt = ctrl_wr && wr_data[CTRL_RUN_BIT] && !run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q  <= '0;
      match_q <= '0;
      run_q   <= 1'b0;
      inv_q   <= 1'b0;
    end else if (wr_en) begin
      case (reg_addr_e'(wr_addr))
        ADDR_CTRL: begin
          if (!run_q) inv_q <= wr_data[CTRL_INV_BIT];
          run_q <= wr_data[CTRL_RUN_BIT];
        end
        ADDR_LOAD:  load_q  <= clamp_load(wr_data);
        ADDR_MATCH: match_q <= wr_data;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/upmatch_pwm_count.sv
module upmatch_pwm_count #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_q,
  input  logic         start_evt,
  input  logic [W-1:0] load_q,
  input  logic [W-1:0] match_q,
  output logic [W-1:0] cnt_q,
  output logic         raw_q,
  output logic         ovf_evt,
  output logic         cmp_evt
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
  localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

  function automatic logic [W-1:0] step(input logic [W-1:0] v);
    return v + ONE;
  endfunction

  assign ovf_evt = run_q && (cnt_q == ALL_ONES);
  assign cmp_evt = run_q && (cnt_q == match_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      raw_q <= 1'b0;
    end else if (start_evt) begin
      cnt_q <= load_q;
      raw_q <= 1'b1;
    end else if (run_q) begin
      if (ovf_evt) begin
        cnt_q <= load_q;
        raw_q <= 1'b1;
      end else begin
        cnt_q <= step(cnt_q);
        if (cmp_evt) raw_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/upmatch_pwm_drive.sv
module upmatch_pwm_drive (
  input  logic run_q,
  input  logic inv_q,
  input  logic raw_q,
  output logic pwm_out
);
  assign pwm_out = run_q ? (raw_q ^ inv_q) : inv_q;
endmodule

// File: rtl/upmatch_pwm.sv
module upmatch_pwm #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic         pwm_out,
  output logic         running,
  output logic         inverted
);
  logic [W-1:0] load_q, match_q, cnt_q;
  logic         run_q, inv_q, start_evt, raw_q, ovf_evt, cmp_evt;

  upmatch_pwm_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .load_q(load_q), .match_q(match_q),
    .run_q(run_q), .inv_q(inv_q), .start_evt(start_evt)
  );

  upmatch_pwm_count #(.W(W)) u_count (
    .clk(clk), .rst_n(rst_n), .run_q(run_q), .start_evt(start_evt),
    .load_q(load_q), .match_q(match_q), .cnt_q(cnt_q), .raw_q(raw_q),
    .ovf_evt(ovf_evt), .cmp_evt(cmp_evt)
  );

  upmatch_pwm_drive u_drive (
    .run_q(run_q), .inv_q(inv_q), .raw_q(raw_q), .pwm_out(pwm_out)
  );

  assign running  = run_q;
  assign inverted = inv_q;
endmodule

// File: rtl/upmatch_pwm_chk.sv
module upmatch_pwm_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         running,
  input logic         inverted,
  input logic         pwm_out,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] load_q,
  input logic         raw_q,
  input logic         ovf_evt,
  input logic         cmp_evt,
  input logic         start_evt
);
  a_r3_start_init: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (running && raw_q && (cnt_q == load_q)));

  a_r4_reload_active: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> raw_q);

  a_r5_match_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_evt && !ovf_evt) |=> !raw_q);

  a_r6_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start_evt) |=> $stable(cnt_q));

  a_r7_polarity_locked: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> $stable(inverted));

  a_r8_load_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    load_q != {W{1'b1}});

  a_r10_stopped_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (pwm_out == inverted));
endmodule

bind upmatch_pwm upmatch_pwm_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .running(running), .inverted(inverted),
  .pwm_out(pwm_out), .cnt_q(cnt_q), .load_q(load_q), .raw_q(raw_q),
  .ovf_evt(ovf_evt), .cmp_evt(cmp_evt), .start_evt(start_evt)
);

// File: tb/upmatch_pwm_test.sv
module upmatch_pwm_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic        pwm_out, running, inverted;
  int checks = 0;
  int errors = 0;

  upmatch_pwm uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out), .running(running),
    .inverted(inverted)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] reload_for(input int p);
    return 32'hFFFF_FFFF - 32'(p) + 32'd1;
  endfunction

  function automatic logic [31:0] compare_for(input int p, input int d);
    return reload_for(p) + 32'(d) - 32'd1;
  endfunction

  function automatic logic ideal(input int k, input int p, input int d, input logic inv);
    return ((k % p) < d) ^ inv;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_and_start(input int p, input int d, input logic inv);
    wr(2'd0, 32'd0);
    wr(2'd1, reload_for(p));
    wr(2'd2, compare_for(p, d));
    wr(2'd0, {30'd0, inv, 1'b1});
  endtask

  task automatic run_pattern(input string req, input int p, input int d, input logic inv, input int n);
    for (int k = 0; k < n; k++) begin
      chk(req, 32'(pwm_out), 32'(ideal(k, p, d, inv)));
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pwm_out", 32'(pwm_out), 32'd0);
    chk("R1 running", 32'(running), 32'd0);
    chk("R1 inverted", 32'(inverted), 32'd0);

    // R2 R3 R4 R5 directed: period 10, duty 3
    set_and_start(10, 3, 1'b0);
    chk("R3 running", 32'(running), 32'd1);
    run_pattern("R4 R5 p10 d3", 10, 3, 1'b0, 30);

    // R9 mixed period: new reload at k0, new compare at k1
    for (int k = 0; k < 30; k++) begin
      logic e;
      e = (k <= 6) ? 1'b1 : (k <= 9) ? 1'b0 : ideal(k - 10, 6, 3, 1'b0);
      chk("R9 mixed period", 32'(pwm_out), 32'(e));
      if (k == 0) begin
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = reload_for(6);
      end else if (k == 1) begin
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = compare_for(6, 3);
      end else begin
        wr_en = 1'b0;
      end
      @(negedge clk);
    end

    // R6 abrupt stop mid-pulse, then fresh restart
    set_and_start(8, 5, 1'b0);
    run_pattern("R6 pre-stop", 8, 5, 1'b0, 2);
    wr(2'd0, 32'd0);
    for (int k = 0; k < 4; k++) begin
      chk("R6 stopped output", 32'(pwm_out), 32'd0);
      chk("R6 running low", 32'(running), 32'd0);
      @(negedge clk);
    end
    wr(2'd0, 32'd1);
    run_pattern("R3 R6 restart fresh", 8, 5, 1'b0, 16);

    // R7 inverted run, polarity write while running ignored, no restart
    set_and_start(6, 2, 1'b1);
    chk("R7 inverted status", 32'(inverted), 32'd1);
    for (int k = 0; k < 18; k++) begin
      chk("R7 R3 inverted waveform", 32'(pwm_out), 32'(ideal(k, 6, 2, 1'b1)));
      if (k == 7) begin
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'd1;
      end else begin
        wr_en = 1'b0;
      end
      @(negedge clk);
    end
    chk("R7 polarity kept", 32'(inverted), 32'd1);
    wr(2'd0, 32'd0);
    chk("R7 stop ignores invert", 32'(inverted), 32'd1);
    chk("R10 idle level inverted", 32'(pwm_out), 32'd1);
    wr(2'd0, 32'd0);
    chk("R7 invert cleared stopped", 32'(inverted), 32'd0);
    chk("R10 idle level normal", 32'(pwm_out), 32'd0);

    // R8 reload clamp gives 2-cycle period
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd2, 32'hFFFF_FFFE);
    wr(2'd0, 32'd1);
    run_pattern("R8 min period", 2, 1, 1'b0, 8);

    // R5 compare on overflow count: reload wins, stays active
    wr(2'd0, 32'd0);
    wr(2'd1, reload_for(4));
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd0, 32'd1);
    run_pattern("R5 overflow priority", 4, 4, 1'b0, 12);

    // R4 R5 R7 random configurations
    for (int t = 0; t < 12; t++) begin
      int p, d;
      logic inv;
      p = 2 + int'($urandom % 30);
      d = 1 + int'($urandom % (p - 1));
      inv = 1'($urandom % 2);
      set_and_start(p, d, inv);
      chk("R7 random polarity", 32'(inverted), 32'(inv));
      run_pattern("R4 R5 random", p, d, inv, 2 * p + 3);
    end

    wr(2'd0, 32'd0);
    chk("R10 final idle", 32'(pwm_out), 32'(inverted));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule